// File: doc/BRIEF.md
# Iterative Multiply Coprocessor

This unit sits beside a processor core and executes the integer multiply instructions that the core hands off. The core raises a request strobe together with the 32-bit instruction word and both 32-bit source operand values. When the word encodes one of the four multiply forms, the unit claims the request at once by raising a hold-off signal. That signal tells the core to keep waiting instead of treating the instruction as illegal. The unit then forms the product one multiplier bit per cycle and finally presents a 32-bit result with a single-cycle completion pulse and a register write request.

Any other instruction word is left alone, with no claim and no response. If the core withdraws its request before the product is finished, the unit abandons the work and stays silent. Register file access is the core's job; this unit only produces the value to be written.

Top module: `mul_copro`

## Requirements
- R1: A request is claimed only when the word has bits [6:0] = 0110011, bits [31:25] = 0000001 and bits [14:12] in 000..011. For any other word, rsp_wait, rsp_ready and rsp_wr all stay low for as long as the request is held.
- R2: For a supported word, rsp_wait is high in the same cycle the request appears. It stays high in every cycle up to and including the completion cycle.
- R3: rsp_ready and rsp_wr are high together for exactly one cycle. That cycle is the 34th cycle of the request, counting the cycle in which the request first appears as the 1st.
- R4: bits [14:12] = 000 returns the low 32 bits of the product.
- R5: bits [14:12] = 001 returns the high 32 bits of the signed × signed product.
- R6: bits [14:12] = 010 returns the high 32 bits of the product with the first operand signed and the second unsigned.
- R7: bits [14:12] = 011 returns the high 32 bits of the unsigned × unsigned product.
- R8: If the request strobe drops before completion, rsp_wait falls in that same cycle and no completion pulse follows. A later request is handled from scratch.
- R9: While rst_n is low, rsp_wait, rsp_ready, rsp_wr and rsp_data are all low.
- R10: rsp_data is zero in every cycle where rsp_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core hands off an instruction |
| req_insn | input | 32 | Instruction word |
| req_op_a | input | 32 | First source operand |
| req_op_b | input | 32 | Second source operand |
| rsp_wait | output | 1 | Request claimed, core must keep waiting |
| rsp_ready | output | 1 | Completion pulse |
| rsp_wr | output | 1 | Register write request, paired with rsp_ready |
| rsp_data | output | 32 | Result value, valid with rsp_ready |

## Verification
The assertions assume that the core keeps the instruction word and both operands unchanged while its strobe is high. They also assume the strobe drops in the cycle after the completion pulse unless a new request follows. The stimulus holds all request inputs constant from the cycle the strobe rises until the completion pulse has been seen, and it releases them at the next falling edge. Withdrawal is tested only by dropping the strobe itself, never by changing the word under a held strobe.

// File: rtl/mulcp_pkg.sv
package mulcp_pkg;
  localparam logic [6:0] OPC_ARITH = 7'b0110011;
  localparam logic [6:0] F7_MULDIV = 7'b0000001;

  typedef enum logic [1:0] {
    OP_LO   = 2'd0,
    OP_HSS  = 2'd1,
    OP_HSU  = 2'd2,
    OP_HUU  = 2'd3
  } mul_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } mul_st_e;
endpackage

// File: rtl/mulcp_decode.sv
module mulcp_decode
  import mulcp_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output logic       hit,
  output mul_op_e    op
);
  always_comb begin
    hit = (opcode == OPC_ARITH) && (funct7 == F7_MULDIV) && !funct3[2];
    op  = mul_op_e'(funct3[1:0]);
  end
endmodule

// File: rtl/mulcp_ctrl.sv
module mulcp_ctrl
  import mulcp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hit,
  output logic load,
  output logic step,
  output logic last,
  output logic done
);
  localparam int CNT_W = $clog2(XLEN);

  mul_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    load   = 1'b0;
    step   = 1'b0;
    last   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid && hit) begin
          load   = 1'b1;
          cnt_en = 1'b1;
          cnt_d  = '0;
          st_d   = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (!req_valid) begin
          st_d = ST_IDLE;
        end else begin
          step   = 1'b1;
          last   = (cnt_q == CNT_W'(XLEN - 1));
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
          if (last) st_d = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign done = (st_q == ST_DONE) && req_valid;
endmodule

// File: rtl/mulcp_datapath.sv
module mulcp_datapath #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic            last,
  input  logic            a_signed,
  input  logic            b_signed,
  input  logic            hi_sel,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic [XLEN-1:0] result
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0]   acc_q, acc_d, mcand_q, mcand_d, addend;
  logic [XLEN-1:0] mplier_q, mplier_d;
  logic            neg_q, hi_q;
  logic            en;

  always_comb begin
    en       = load || step;
    acc_d    = acc_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    addend   = '0;
    if (load) begin
      acc_d    = '0;
      mcand_d  = {{XLEN{a_signed & op_a[XLEN-1]}}, op_a};
      mplier_d = op_b;
    end else if (step) begin
      if (mplier_q[0]) addend = (last && neg_q) ? (~mcand_q + 1'b1) : mcand_q;
      acc_d    = acc_q + addend;
      mcand_d  = mcand_q << 1;
      mplier_d = mplier_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      neg_q    <= 1'b0;
      hi_q     <= 1'b0;
    end else if (en) begin
      acc_q    <= acc_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      if (load) begin
        neg_q <= b_signed;
        hi_q  <= hi_sel;
      end
    end
  end

  assign result = hi_q ? acc_q[PW-1:XLEN] : acc_q[XLEN-1:0];
endmodule

// File: rtl/mul_copro.sv
module mul_copro
  import mulcp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [31:0]     req_insn,
  input  logic [XLEN-1:0] req_op_a,
  input  logic [XLEN-1:0] req_op_b,
  output logic            rsp_wait,
  output logic            rsp_ready,
  output logic            rsp_wr,
  output logic [XLEN-1:0] rsp_data
);
  logic            hit, load, step, last, done;
  mul_op_e         op;
  logic [XLEN-1:0] result;
  logic            unused_fields;

  assign unused_fields = ^{req_insn[24:15], req_insn[11:7]};

  mulcp_decode u_dec (
    .opcode (req_insn[6:0]),
    .funct3 (req_insn[14:12]),
    .funct7 (req_insn[31:25]),
    .hit    (hit),
    .op     (op)
  );

  mulcp_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .hit       (hit),
    .load      (load),
    .step      (step),
    .last      (last),
    .done      (done)
  );

  mulcp_datapath #(.XLEN(XLEN)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .last     (last),
    .a_signed (op == OP_HSS || op == OP_HSU),
    .b_signed (op == OP_HSS),
    .hi_sel   (op != OP_LO),
    .op_a     (req_op_a),
    .op_b     (req_op_b),
    .result   (result)
  );

  assign rsp_wait  = rst_n && req_valid && hit;
  assign rsp_ready = rst_n && done;
  assign rsp_wr    = rst_n && done;
  assign rsp_data  = rsp_ready ? result : '0;
endmodule

// File: rtl/mulcp_checker.sv
module mulcp_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            rsp_wait,
  input logic            rsp_ready,
  input logic            rsp_wr,
  input logic [XLEN-1:0] rsp_data
);
  localparam int LAT   = XLEN + 1;
  localparam int RUN_W = $clog2(LAT + 2);

  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (rsp_ready || !rsp_wait) run_d = '0;
    else if (run_q != RUN_W'(LAT + 1)) run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  p_silent_without_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_wait && !rsp_ready && !rsp_wr));
  p_ready_inside_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> rsp_wait);
  p_wr_pairs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wr == rsp_ready);
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (run_q == RUN_W'(LAT)));
  p_data_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready |-> (rsp_data == '0));
endmodule

bind mul_copro mulcp_checker #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .rsp_wait  (rsp_wait),
  .rsp_ready (rsp_ready),
  .rsp_wr    (rsp_wr),
  .rsp_data  (rsp_data)
);

// File: tb/mul_copro_tb_top.sv
module mul_copro_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = CLK_PERIOD / 4;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_insn, req_op_a, req_op_b;
  logic        rsp_wait, rsp_ready, rsp_wr;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mul_copro dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_insn(req_insn),
    .req_op_a(req_op_a), .req_op_b(req_op_b), .rsp_wait(rsp_wait),
    .rsp_ready(rsp_ready), .rsp_wr(rsp_wr), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3, input logic [6:0] opc);
    return {f7, 5'd2, 5'd1, f3, 5'd3, opc};
  endfunction

  function automatic logic [31:0] model(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] xa, xb, p;
    xa = (f3 == 3'd1 || f3 == 3'd2) ? {{32{a[31]}}, a} : {32'd0, a};
    xb = (f3 == 3'd1) ? {{32{b[31]}}, b} : {32'd0, b};
    p  = xa * xb;
    return (f3 == 3'd0) ? p[31:0] : p[63:32];
  endfunction

  // Driver: one supported request, expected item goes to the scoreboard
  task automatic run_op(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b, input string tag);
    int n;
    bit seen = 1'b0;
    exp_q.push_back(model(f3, a, b));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_insn  = mk(7'b0000001, f3, 7'b0110011);
    req_op_a  = a;
    req_op_b  = b;
    for (n = 1; n <= 60 && !seen; n++) begin
      #Q;
      if (!rsp_wait) chk(1'b0, "R2 wait held", {31'd0, rsp_wait}, 32'd1);
      if (rsp_ready) begin
        seen = 1'b1;
        chk(n == 34, "R3 completion cycle", n, 34);
        chk(rsp_wait, "R2 wait in ready cycle", {31'd0, rsp_wait}, 32'd1);
      end
      @(negedge clk);
    end
    if (!seen) chk(1'b0, "R3 no completion", 32'd0, 32'd1);
    req_valid = 1'b0;
  endtask

  task automatic run_unsup(input logic [31:0] insn, input string tag);
    bit quiet = 1'b1;
    @(negedge clk);
    req_valid = 1'b1;
    req_insn  = insn;
    req_op_a  = 32'h1234_5678;
    req_op_b  = 32'h0000_0003;
    for (int i = 0; i < 40; i++) begin
      #Q;
      if (rsp_wait || rsp_ready || rsp_wr) quiet = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(quiet, tag, {29'd0, rsp_wait, rsp_ready, rsp_wr}, 32'd0);
  endtask

  task automatic run_abort(input int hold);
    bit quiet = 1'b1;
    @(negedge clk);
    req_valid = 1'b1;
    req_insn  = mk(7'b0000001, 3'd0, 7'b0110011);
    req_op_a  = 32'd9;
    req_op_b  = 32'd9;
    repeat (hold) @(negedge clk);
    #Q;
    chk(rsp_wait, "R2 wait before abort", {31'd0, rsp_wait}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    #Q;
    chk(!rsp_wait, "R8 wait falls on abort", {31'd0, rsp_wait}, 32'd0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      #Q;
      if (rsp_ready || rsp_wr) quiet = 1'b0;
    end
    chk(quiet, "R8 no pulse after abort", {30'd0, rsp_ready, rsp_wr}, 32'd0);
  endtask

  // Monitor: pops the scoreboard on each completion pulse
  initial begin
    forever begin
      @(negedge clk);
      #Q;
      if (rst_n && rsp_ready) begin
        chk(rsp_wr, "R3 wr with ready", {31'd0, rsp_wr}, 32'd1);
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected result", rsp_data, 32'd0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rsp_data == e, t, rsp_data, e);
        end
      end else if (rst_n && rsp_data != 32'd0) begin
        chk(1'b0, "R10 data outside ready", rsp_data, 32'd0);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_insn  = 32'd0;
    req_op_a  = 32'd0;
    req_op_b  = 32'd0;
    repeat (3) @(negedge clk);
    req_valid = 1'b1;
    req_insn  = mk(7'b0000001, 3'd0, 7'b0110011);
    #Q;
    chk({rsp_wait, rsp_ready, rsp_wr} == 3'b0 && rsp_data == 32'd0, "R9 reset outputs",
        {rsp_wait, rsp_ready, rsp_wr, rsp_data[28:0]}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n     = 1'b1;

    run_op(3'd0, 32'd7, 32'd6, "R4 mul small");
    run_op(3'd0, 32'hFFFF_FFFD, 32'd5, "R4 mul negative");
    run_op(3'd0, 32'hDEAD_BEEF, 32'h1234_5679, "R4 mul wide");
    run_op(3'd1, 32'h8000_0000, 32'h8000_0000, "R5 mulh min*min");
    run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 mulh -1*-1");
    run_op(3'd1, 32'h7FFF_FFFF, 32'h8000_0000, "R5 mulh max*min");
    run_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 mulhsu -1*max");
    run_op(3'd2, 32'h4000_0000, 32'h8000_0001, "R6 mulhsu pos*big");
    run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 mulhu max*max");
    run_op(3'd3, 32'h1234_5678, 32'h9ABC_DEF0, "R7 mulhu mixed");
    run_unsup(mk(7'b0000001, 3'd4, 7'b0110011), "R1 divide word ignored");
    run_unsup(mk(7'b0000000, 3'd0, 7'b0110011), "R1 add word ignored");
    run_unsup(mk(7'b0000001, 3'd0, 7'b0010011), "R1 other opcode ignored");
    run_unsup(mk(7'b0100001, 3'd3, 7'b0110011), "R1 funct7 variant ignored");
    run_abort(5);
    run_abort(32);
    run_op(3'd0, 32'd123, 32'd456, "R8 fresh after abort");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule